// File: doc/BRIEF.md
# I2C SCL Phase Generator

This block produces the SCL waveform for an I2C master. It drives the line low for a programmed number of cycles and then releases it. It waits until the released line is actually seen high, and then counts out a programmed high time. Each speed mode has its own pair of high/low counts, and a 2-bit mode field picks the pair that is in use. While a run request is held, the block produces back-to-back clock periods. It also gives the bit engine a strobe for driving SDA and a strobe for sampling it.

The block is gated by an enable handshake. Dropping the enable request does not stop the clock at once. The bit engine keeps the run request asserted until it has finished its byte and STOP. The block then ends the current period, goes idle, and only after that lowers its enable status. Mode and count writes are accepted only while the enable status is low, so the phase lengths cannot change in the middle of a transfer.

SCL is open-drain. `scl_oe_o` high pulls the line low, and `scl_i` is the wired line as seen at the pin. Before it is used, `scl_i` passes through a two-flop synchronizer.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `drive_stb_o`, `sample_stb_o`, `stretch_o` and `en_status_o` are all 0.
- R2: The mode field (control bits [2:1], port `cfg_mode_i`) selects the count pair in use: 1 is standard, 2 is fast, 3 is high-speed, and 0 is treated as standard. The bank codes on `cfg_cnt_sel_i` are the same; code 0 writes nothing.
- R3: Mode and count writes are ignored while `en_status_o` is 1 and take effect when it is 0. A count write loads both the high and the low value of the addressed bank.
- R4: The low phase holds `scl_oe_o` at 1 for exactly lcnt+1 cycles.
- R5: In the high phase `scl_oe_o` is 0. The high count advances only on cycles where the synchronized SCL is high, and the phase ends after hcnt+1 such cycles. The synchronizer has two stages, so 2 cycles of low line after release are expected. `stretch_o` is 1 on every later cycle of the same high phase where the synchronized line is still low.
- R6: `drive_stb_o` is a one-cycle pulse on the first cycle of every low phase.
- R7: `sample_stb_o` pulses once per high phase, on the counted-high cycle whose count equals floor(hcnt/2).
- R8: `en_status_o` rises on the cycle after `en_req_i` is seen while the block is idle. While `en_status_o` is 0, no clock period starts and `scl_oe_o` stays 0.
- R9: With `en_req_i` low, `en_status_o` stays 1 while `run_i` is high or a period is in progress. It falls one cycle after the block is idle with `run_i` low, and SCL is then released.
- R10: The count banks reset to high/low values of 0x75/0x7C for standard, 0x15/0x21 for fast and 0x07/0x0E for high-speed, and the mode resets to standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_we_i | input | 1 | Write strobe for the mode field |
| cfg_mode_i | input | 2 | Speed-mode value (control bits [2:1]) |
| cfg_cnt_we_i | input | 1 | Write strobe for a count pair |
| cfg_cnt_sel_i | input | 2 | Bank code for the count write (1..3) |
| cfg_hcnt_i | input | CW | High-count value to write |
| cfg_lcnt_i | input | CW | Low-count value to write |
| en_req_i | input | 1 | Enable request level |
| run_i | input | 1 | Bit engine requests clock periods |
| scl_i | input | 1 | Sensed SCL line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| drive_stb_o | output | 1 | First cycle of a low phase |
| sample_stb_o | output | 1 | Middle of the counted high phase |
| stretch_o | output | 1 | Released line held low by another device |
| en_status_o | output | 1 | Controller enabled state |

## Verification
The main function is run in all four mode-field values against banks that have distinct low lengths. A wrong bank decode, or the wrong handling of mode 0, therefore shows up as a wrong low length. The zero count in the high-speed bank checks the one-cycle boundary of both phases. Holding the line low after release separates the expected synchronizer delay from a true stretch, and also shows whether counting stalls. Writes made while enabled, a disable issued in the middle of a run, and a run request while disabled each separate a correct handshake from one that leaks configuration changes or starts clocks early.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_STD  = 2'd1;
  localparam logic [1:0] MODE_FAST = 2'd2;
  localparam logic [1:0] MODE_HS   = 2'd3;
  localparam int unsigned NUM_BANKS = 3;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // reset to 1: an idle bus is pulled up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else if (STAGES == 1) pipe_q <= d_i;
    else pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank
  import scl_gen_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter logic [CW-1:0] STD_HCNT  = 'h75,
  parameter logic [CW-1:0] STD_LCNT  = 'h7C,
  parameter logic [CW-1:0] FAST_HCNT = 'h15,
  parameter logic [CW-1:0] FAST_LCNT = 'h21,
  parameter logic [CW-1:0] HS_HCNT   = 'h07,
  parameter logic [CW-1:0] HS_LCNT   = 'h0E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_i,
  input  logic          cnt_we_i,
  input  logic [1:0]    cnt_sel_i,
  input  logic [CW-1:0] hcnt_i,
  input  logic [CW-1:0] lcnt_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] lcnt_o
);
  localparam logic [CW-1:0] H_RST [NUM_BANKS] = '{STD_HCNT, FAST_HCNT, HS_HCNT};
  localparam logic [CW-1:0] L_RST [NUM_BANKS] = '{STD_LCNT, FAST_LCNT, HS_LCNT};

  logic [1:0]    mode_q;
  logic [CW-1:0] hbank_q [NUM_BANKS];
  logic [CW-1:0] lbank_q [NUM_BANKS];
  logic [1:0]    sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STD;
    else if (mode_we_i && !lock_i) mode_q <= mode_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [1:0] CODE = 2'(b + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hbank_q[b] <= H_RST[b];
        lbank_q[b] <= L_RST[b];
      end else if (cnt_we_i && !lock_i && cnt_sel_i == CODE) begin
        hbank_q[b] <= hcnt_i;
        lbank_q[b] <= lcnt_i;
      end
    end
  end

  // mode 0 is reserved and falls back to the standard bank
  always_comb begin
    sel_idx = (mode_q == 2'd0) ? 2'd0 : mode_q - 2'd1;
    hcnt_o  = hbank_q[sel_idx];
    lcnt_o  = lbank_q[sel_idx];
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_req_i,
  input  logic          run_i,
  input  logic          scl_hi_i,
  input  logic [CW-1:0] hcnt_i,
  input  logic [CW-1:0] lcnt_i,
  output logic          scl_oe_o,
  output logic          drive_stb_o,
  output logic          sample_stb_o,
  output logic          stretch_o,
  output logic          en_status_o
);
  localparam int unsigned WW = $clog2(SYNC_STAGES + 1);
  localparam logic [WW-1:0] WMAX = WW'(SYNC_STAGES);

  phase_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] wait_q;
  logic          en_q;
  logic [CW-1:0] mid_cnt;

  assign mid_cnt = hcnt_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      en_q   <= 1'b0;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          if (!en_q && en_req_i) en_q <= 1'b1;
          else if (en_q && !en_req_i && !run_i) en_q <= 1'b0;
          if (en_q && run_i) begin
            st_q  <= PH_LOW;
            cnt_q <= '0;
          end
        end
        PH_LOW: begin
          if (cnt_q == lcnt_i) begin
            st_q   <= PH_HIGH;
            cnt_q  <= '0;
            wait_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (!scl_hi_i) begin
            if (wait_q != WMAX) wait_q <= wait_q + 1'b1;
          end else if (cnt_q == hcnt_i) begin
            st_q  <= run_i ? PH_LOW : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe_o     = (st_q == PH_LOW);
  assign drive_stb_o  = (st_q == PH_LOW) && (cnt_q == '0);
  assign sample_stb_o = (st_q == PH_HIGH) && scl_hi_i && (cnt_q == mid_cnt);
  assign stretch_o    = (st_q == PH_HIGH) && !scl_hi_i && (wait_q == WMAX);
  assign en_status_o  = en_q;
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CW-1:0] STD_HCNT  = 'h75,
  parameter logic [CW-1:0] STD_LCNT  = 'h7C,
  parameter logic [CW-1:0] FAST_HCNT = 'h15,
  parameter logic [CW-1:0] FAST_LCNT = 'h21,
  parameter logic [CW-1:0] HS_HCNT   = 'h07,
  parameter logic [CW-1:0] HS_LCNT   = 'h0E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_mode_we_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_cnt_we_i,
  input  logic [1:0]    cfg_cnt_sel_i,
  input  logic [CW-1:0] cfg_hcnt_i,
  input  logic [CW-1:0] cfg_lcnt_i,
  input  logic          en_req_i,
  input  logic          run_i,
  input  logic          scl_i,
  output logic          scl_oe_o,
  output logic          drive_stb_o,
  output logic          sample_stb_o,
  output logic          stretch_o,
  output logic          en_status_o
);
  logic          scl_hi;
  logic [CW-1:0] sel_hcnt;
  logic [CW-1:0] sel_lcnt;
  logic          en_status;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_i),
    .q_o    (scl_hi)
  );

  scl_cfg_bank #(
    .CW(CW), .STD_HCNT(STD_HCNT), .STD_LCNT(STD_LCNT),
    .FAST_HCNT(FAST_HCNT), .FAST_LCNT(FAST_LCNT),
    .HS_HCNT(HS_HCNT), .HS_LCNT(HS_LCNT)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (en_status),
    .mode_we_i (cfg_mode_we_i),
    .mode_i    (cfg_mode_i),
    .cnt_we_i  (cfg_cnt_we_i),
    .cnt_sel_i (cfg_cnt_sel_i),
    .hcnt_i    (cfg_hcnt_i),
    .lcnt_i    (cfg_lcnt_i),
    .hcnt_o    (sel_hcnt),
    .lcnt_o    (sel_lcnt)
  );

  scl_phase_fsm #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_req_i     (en_req_i),
    .run_i        (run_i),
    .scl_hi_i     (scl_hi),
    .hcnt_i       (sel_hcnt),
    .lcnt_i       (sel_lcnt),
    .scl_oe_o     (scl_oe_o),
    .drive_stb_o  (drive_stb_o),
    .sample_stb_o (sample_stb_o),
    .stretch_o    (stretch_o),
    .en_status_o  (en_status)
  );

  assign en_status_o = en_status;
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          scl_oe_o,
  input logic          drive_stb_o,
  input logic          sample_stb_o,
  input logic          stretch_o,
  input logic          en_status_o,
  input logic [CW-1:0] sel_hcnt,
  input logic [CW-1:0] sel_lcnt
);
  // R3
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_status_o) |-> ($stable(sel_hcnt) && $stable(sel_lcnt)));

  // R6
  drive_on_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> drive_stb_o);

  // R6
  drive_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_stb_o |=> !drive_stb_o);

  // R7
  sample_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |-> (!scl_oe_o && !stretch_o));

  // R5
  stretch_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |-> !scl_oe_o);

  // R8
  no_clock_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_status_o |-> !scl_oe_o);

  // R9
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_status_o) |-> (!scl_oe_o && !$past(run_i)));
endmodule

bind scl_phase_gen scl_phase_gen_chk #(.CW(CW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .scl_oe_o     (scl_oe_o),
  .drive_stb_o  (drive_stb_o),
  .sample_stb_o (sample_stb_o),
  .stretch_o    (stretch_o),
  .en_status_o  (en_status_o),
  .sel_hcnt     (sel_hcnt),
  .sel_lcnt     (sel_lcnt)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [1:0] mode_v = 2'd0;
  logic cnt_we = 1'b0;
  logic [1:0] cnt_sel = 2'd0;
  logic [CW-1:0] hcnt_v = '0;
  logic [CW-1:0] lcnt_v = '0;
  logic en_req = 1'b0;
  logic run = 1'b0;
  logic hold = 1'b0;
  logic scl_line;
  logic scl_oe, drv_stb, smp_stb, stretch, en_st;

  always #2 clk = ~clk;

  assign scl_line = ~(scl_oe | hold);

  scl_phase_gen #(.CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_we_i(mode_we), .cfg_mode_i(mode_v),
    .cfg_cnt_we_i(cnt_we), .cfg_cnt_sel_i(cnt_sel),
    .cfg_hcnt_i(hcnt_v), .cfg_lcnt_i(lcnt_v),
    .en_req_i(en_req), .run_i(run), .scl_i(scl_line),
    .scl_oe_o(scl_oe), .drive_stb_o(drv_stb), .sample_stb_o(smp_stb),
    .stretch_o(stretch), .en_status_o(en_st)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural reference: phase 0 idle, 1 low, 2 high
  int m_st, m_cnt, m_w, m_mode;
  bit m_en, m_s1, m_s2;
  int m_h[4];
  int m_l[4];

  function automatic int bank_of(int md);
    return (md == 0) ? 1 : md;
  endfunction

  always @(posedge clk) begin
    int hs, ls;
    bit ns1, ns2;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_w = 0; m_en = 0; m_s1 = 1; m_s2 = 1; m_mode = 1;
      m_h[1] = 'h75; m_l[1] = 'h7C; m_h[2] = 'h15; m_l[2] = 'h21;
      m_h[3] = 'h07; m_l[3] = 'h0E;
    end else begin
      hs = m_h[bank_of(m_mode)];
      ls = m_l[bank_of(m_mode)];
      ns1 = scl_line;
      ns2 = m_s1;
      if (m_st == 0) begin
        if (!m_en && en_req) m_en = 1;
        else if (m_en && !en_req && !run) m_en = 0;
        else if (m_en && run) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (m_cnt == ls) begin m_st = 2; m_cnt = 0; m_w = 0; end
        else m_cnt++;
      end else begin
        if (!m_s2) begin if (m_w < 2) m_w++; end
        else if (m_cnt == hs) begin m_st = run ? 1 : 0; m_cnt = 0; end
        else m_cnt++;
      end
      if (!(m_en && !(m_st == 1 && m_cnt == 0 && run && hs >= 0 && 0))) begin end
      m_s1 = ns1;
      m_s2 = ns2;
    end
  end

  // config writes use the enable state from before the edge
  bit en_before;
  always @(posedge clk) begin
    if (rst_n && !en_before) begin
      if (mode_we) m_mode = mode_v;
      if (cnt_we && cnt_sel != 0) begin m_h[cnt_sel] = hcnt_v; m_l[cnt_sel] = lcnt_v; end
    end
  end
  always @(negedge clk) en_before = m_en;

  int drv_n, smp_n, str_n, oe_n;

  always @(negedge clk) begin
    int hs;
    if (rst_n && !done) begin
      hs = m_h[bank_of(m_mode)];
      chk(scl_oe == (m_st == 1), "R4 scl_oe", scl_oe, m_st == 1);
      chk(drv_stb == (m_st == 1 && m_cnt == 0), "R6 drive_stb", drv_stb, m_st == 1 && m_cnt == 0);
      chk(smp_stb == (m_st == 2 && m_s2 && m_cnt == hs / 2), "R7 sample_stb", smp_stb,
          m_st == 2 && m_s2 && m_cnt == hs / 2);
      chk(stretch == (m_st == 2 && !m_s2 && m_w == 2), "R5 stretch", stretch,
          m_st == 2 && !m_s2 && m_w == 2);
      chk(en_st == m_en, "R8 en_status", en_st, m_en);
      drv_n += drv_stb; smp_n += smp_stb; str_n += stretch; oe_n += scl_oe;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [1:0] md);
    @(negedge clk); mode_we = 1; mode_v = md;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_cnt(input logic [1:0] sel, input int h, input int l);
    @(negedge clk); cnt_we = 1; cnt_sel = sel; hcnt_v = CW'(h); lcnt_v = CW'(l);
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic enable_wait();
    @(negedge clk); en_req = 1;
    for (int i = 0; i < 20 && !en_st; i++) @(negedge clk);
  endtask

  task automatic disable_wait(input string tag);
    @(negedge clk); run = 0; en_req = 0;
    for (int i = 0; i < 3000 && en_st; i++) @(negedge clk);
    chk(en_st == 0, tag, en_st, 0);
    chk(scl_oe == 0, tag, scl_oe, 0);
  endtask

  task automatic measure_low(input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < 3000 && !scl_oe; i++) @(negedge clk);
    while (scl_oe && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    // R1
    chk(scl_oe == 0 && drv_stb == 0 && smp_stb == 0 && stretch == 0 && en_st == 0,
        "R1 reset outputs", {scl_oe, drv_stb, smp_stb, stretch, en_st}, 0);

    // R10 default standard low = 0x7C+1
    enable_wait();
    chk(en_st == 1, "R8 enable rise", en_st, 1);
    run = 1;
    measure_low(125, "R10 default low");
    disable_wait("R9 disable after default run");

    // R8 run while disabled
    oe_n = 0; run = 1; cyc(40);
    chk(oe_n == 0, "R8 no clock while disabled", oe_n, 0);
    run = 0;

    wr_cnt(2'd1, 3, 4);
    wr_cnt(2'd2, 5, 2);
    wr_cnt(2'd3, 0, 0);
    wr_cnt(2'd0, 9, 9);

    // R2 fast bank, with R7/R6 strobe counts
    wr_mode(2'd2);
    enable_wait();
    drv_n = 0; smp_n = 0;
    run = 1;
    measure_low(3, "R2 fast low");
    cyc(40);
    disable_wait("R9 fast stop");
    chk(smp_n == drv_n && drv_n > 0, "R7 one sample per period", smp_n, drv_n);

    // R2/R4 high-speed bank with zero counts
    wr_mode(2'd3);
    enable_wait(); run = 1;
    measure_low(1, "R4 zero low count");
    cyc(20);
    disable_wait("R9 hs stop");

    wr_mode(2'd1);
    enable_wait(); run = 1;
    measure_low(5, "R2 standard low");
    disable_wait("R9 std stop");

    wr_mode(2'd0);
    enable_wait(); run = 1;
    measure_low(5, "R2 mode0 maps standard");
    run = 0;

    // R3 writes while enabled are ignored
    wr_mode(2'd3);
    wr_cnt(2'd1, 3, 9);
    run = 1;
    measure_low(5, "R3 write ignored while enabled");
    disable_wait("R9 after ignored write");
    wr_cnt(2'd1, 3, 9);
    enable_wait(); run = 1;
    measure_low(10, "R3 write accepted when disabled");

    // R5 clock stretching
    str_n = 0;
    for (int i = 0; i < 3000 && scl_oe; i++) @(negedge clk);
    hold = 1; cyc(12); hold = 0;
    cyc(30);
    chk(str_n > 0, "R5 stretch seen", str_n, 1);

    // R9 disable mid-run
    en_req = 0; cyc(30);
    chk(en_st == 1, "R9 busy keeps enable", en_st, 1);
    disable_wait("R9 idle clears enable");
    cyc(10);
    chk(scl_line == 1, "R9 scl released", scl_line, 1);

    finish_up();
  end
endmodule